// File: doc/BRIEF.md
# Wiper Code Register with Non-Volatile Commit

This block holds the 7-bit code that sets a digital potentiometer's wiper. It sits behind a serial bus front end that has already decoded a transaction. The front end hands over three kinds of event: a write strobe that fires when a data byte is acknowledged, a read request for one register, and bus events that mark the end of a transaction, either STOP or repeated START. The block has two mapped registers. Address 00h is the live wiper code. Address 02h is a volatile control register, and its only stored bit is the mode bit in bit 7.

When the mode bit is clear, a write to 00h changes the live code at once. The same value is also staged for the non-volatile store. The store is written only when the transaction ends in a STOP. If it ends in a repeated START instead, the staged value is dropped. A store write keeps the busy flag high for a fixed number of clock cycles. When the mode bit is set, a write to 00h changes only the live code. After every reset, the block waits a recall delay with busy high, then copies the stored initial value into the live code. The stored cell keeps its contents across reset and starts out holding 40h.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While reset is low, `wiper` is 00h and `busy` is 1. After reset is released, `busy` stays high for exactly RECALL_CYCLES clock cycles. When `busy` falls, `wiper` equals the stored initial value. That value is 40h before anything has ever been committed.
- R2: With the mode bit at 0, `wr_en` to address 00h sets `wiper` to `wr_data[6:0]` one cycle later, and the value is staged for the store.
- R3: With the mode bit at 1, a write to 00h changes `wiper` but stages nothing. A following `stop_evt` leaves `busy` low.
- R4: One cycle after `rd_en` with `rd_addr` 00h, `rd_data` is `{1'b0, wiper}`. This holds whatever the mode bit is.
- R5: A write to 02h loads the mode bit from `wr_data[7]`, and all other bits of the byte are ignored. A read of 02h returns 80h when the mode bit is 1 and 00h when it is 0, and the register is 00h after reset. A mode change alters neither `wiper` nor the stored value.
- R6: A `stop_evt` while a value is staged raises `busy` on the next cycle and holds it for exactly WRITE_CYCLES cycles. The staged value becomes the stored initial value, which the next reset recalls.
- R7: A `restart_evt` discards the staged value, so a later `stop_evt` starts no store write.
- R8: While `busy` is high, writes and `stop_evt` are ignored: `wiper` and the stored value stay as they were.
- R9: A write to any address other than 00h and 02h changes nothing, and a read of such an address returns 00h.
- R10: When several writes to 00h come before one STOP, the last value written is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the stored cell is not cleared by it |
| wr_en | input | 1 | Write strobe, one cycle per acknowledged data byte |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_en | input | 1 | Read request, one cycle |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| stop_evt | input | 1 | One-cycle pulse: transaction ended with STOP |
| restart_evt | input | 1 | One-cycle pulse: transaction ended with repeated START |
| busy | output | 1 | High during the power-up recall and during a store write |
| wiper | output | 7 | Live wiper code |

## Verification
The assertions watch the following on every cycle:
- The read path returns the live code for 00h, zero for unmapped addresses, and zero low bits for 02h.
- The wiper code stays frozen while busy, except on the recall cycle.
- A STOP with a staged value starts busy.
- The stored cell changes only inside a busy window, and no busy window runs past its limit.

The bench scenarios are the only way to show three things. First, that a value reaches the store only through the mode-0, STOP-terminated path: that value shows up only when the next reset recalls it. Second, that a repeated START or a busy period drops a staged or late write. Third, that the busy windows have the exact lengths.

// File: rtl/wnv_pkg.sv
// Package: shared constants and types for the wiper code register block.
// Assumes an 8-bit register address and an 8-bit data byte.
package wnv_pkg;
    localparam logic [7:0] ADDR_WIPER = 8'h00;
    localparam logic [7:0] ADDR_CTRL  = 8'h02;
    localparam int         MODE_BIT   = 7;

    typedef enum logic [1:0] {
        NV_RECALL = 2'd0,
        NV_IDLE   = 2'd1,
        NV_WRITE  = 2'd2
    } nv_state_e;
endpackage

// File: rtl/wnv_store.sv
// Module: wnv_store
// Models the non-volatile initial value cell and its timing. After reset it
// counts RECALL_CYCLES and then pulses recall_pulse so that the register file
// loads the stored code. A commit accepted in idle captures the value and
// holds busy for WRITE_CYCLES cycles; the cell is updated on the last one.
// Assumes commit_req is a one-cycle pulse. The cell itself has no reset, so
// its contents survive rst_n. It starts at INIT_CODE.
module wnv_store
    import wnv_pkg::*;
#(
    parameter int                 WIPER_W       = 7,
    parameter logic [WIPER_W-1:0] INIT_CODE     = 7'h40,
    parameter int                 WRITE_CYCLES  = 20,
    parameter int                 RECALL_CYCLES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_req,
    input  logic [WIPER_W-1:0] commit_val,
    output logic               busy,
    output logic               recall_pulse,
    output logic [WIPER_W-1:0] stored
);
    localparam int CNT_MAX = (WRITE_CYCLES > RECALL_CYCLES) ? WRITE_CYCLES : RECALL_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    nv_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [WIPER_W-1:0] staged_q;
    logic [WIPER_W-1:0] nv_q = INIT_CODE;
    logic               accept;
    logic               write_done;

    assign accept       = (state_q == NV_IDLE) && commit_req;
    assign write_done   = (state_q == NV_WRITE) && (cnt_q == '0);
    assign recall_pulse = (state_q == NV_RECALL) && (cnt_q == '0);
    assign busy         = (state_q != NV_IDLE);
    assign stored       = nv_q;

    // Sequencer: recall window after reset, write window after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NV_RECALL;
            cnt_q   <= CNT_W'(RECALL_CYCLES - 1);
        end else begin
            case (state_q)
                NV_RECALL: begin
                    if (cnt_q == '0) state_q <= NV_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                NV_IDLE: begin
                    if (accept) begin
                        state_q <= NV_WRITE;
                        cnt_q   <= CNT_W'(WRITE_CYCLES - 1);
                    end
                end
                NV_WRITE: begin
                    if (cnt_q == '0) state_q <= NV_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= NV_IDLE;
            endcase
        end
    end

    // Capture the value to program when a commit is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      staged_q <= INIT_CODE;
        else if (accept) staged_q <= commit_val;
    end

    // Non-volatile cell: written only at the end of a write window.
    always_ff @(posedge clk) begin
        if (write_done) nv_q <= staged_q;
    end
endmodule

// File: rtl/wnv_regs.sv
// Module: wnv_regs
// Register file: the live wiper code, the mode bit and the staging of
// values for the store. Applies the mode rule, drops the staged value on a
// repeated START, and asks for a commit on STOP. Ignores writes while busy.
// Assumes strobes and events are one-cycle pulses from the bus front end.
module wnv_regs
    import wnv_pkg::*;
#(
    parameter int WIPER_W = 7,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               stop_evt,
    input  logic               restart_evt,
    input  logic               busy,
    input  logic               recall_pulse,
    input  logic [WIPER_W-1:0] recall_val,
    output logic [WIPER_W-1:0] wiper,
    output logic               commit_req,
    output logic [WIPER_W-1:0] commit_val
);
    logic [WIPER_W-1:0] wr_q;
    logic               mode_q;
    logic               pend_q;
    logic [WIPER_W-1:0] pval_q;
    logic               wr_ok;
    logic               hit_wiper;
    logic               hit_ctrl;

    assign wr_ok      = wr_en && !busy;
    assign hit_wiper  = wr_ok && (wr_addr == ADDR_W'(ADDR_WIPER));
    assign hit_ctrl   = wr_ok && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wiper      = wr_q;
    assign commit_req = stop_evt && pend_q;
    assign commit_val = pval_q;

    // Live wiper code: loaded by recall or by an accepted write to 00h.
    always_ff @(posedge clk) begin
        if (!rst_n)            wr_q <= '0;
        else if (recall_pulse) wr_q <= recall_val;
        else if (hit_wiper)    wr_q <= wr_data[WIPER_W-1:0];
    end

    // Mode bit: volatile, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (hit_ctrl) mode_q <= wr_data[MODE_BIT];
    end

    // Staging: mode-0 writes arm a commit; a transaction end disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pval_q <= '0;
        end else if (!busy && (stop_evt || restart_evt)) begin
            pend_q <= 1'b0;
        end else if (hit_wiper && !mode_q) begin
            pend_q <= 1'b1;
            pval_q <= wr_data[WIPER_W-1:0];
        end
    end

    // Registered read mux; unmapped addresses read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == ADDR_W'(ADDR_WIPER))     rd_data <= DATA_W'(wr_q);
            else if (rd_addr == ADDR_W'(ADDR_CTRL)) rd_data <= DATA_W'({mode_q, 7'b0});
            else                                    rd_data <= '0;
        end
    end
endmodule

// File: rtl/wiper_nv_ctrl.sv
// Module: wiper_nv_ctrl (top)
// Wiper code register with a non-volatile initial value. Connects the
// register file to the store model. Assumes a bus front end that turns bus
// traffic into write strobes, read requests and STOP or repeated-START pulses.
module wiper_nv_ctrl #(
    parameter int                 WIPER_W       = 7,
    parameter int                 ADDR_W        = 8,
    parameter int                 DATA_W        = 8,
    parameter logic [WIPER_W-1:0] INIT_CODE     = 7'h40,
    parameter int                 WRITE_CYCLES  = 20,
    parameter int                 RECALL_CYCLES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               stop_evt,
    input  logic               restart_evt,
    output logic               busy,
    output logic [WIPER_W-1:0] wiper
);
    logic               recall_pulse;
    logic [WIPER_W-1:0] stored;
    logic               commit_req;
    logic [WIPER_W-1:0] commit_val;

    wnv_regs #(
        .WIPER_W(WIPER_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_evt(stop_evt), .restart_evt(restart_evt),
        .busy(busy), .recall_pulse(recall_pulse), .recall_val(stored),
        .wiper(wiper), .commit_req(commit_req), .commit_val(commit_val)
    );

    wnv_store #(
        .WIPER_W(WIPER_W), .INIT_CODE(INIT_CODE),
        .WRITE_CYCLES(WRITE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit_req(commit_req), .commit_val(commit_val),
        .busy(busy), .recall_pulse(recall_pulse), .stored(stored)
    );
endmodule

// File: rtl/wiper_nv_ctrl_chk.sv
// Module: wiper_nv_ctrl_chk
// Cycle-by-cycle checker attached to wiper_nv_ctrl through bind. It watches
// the ports plus the staged flag and the stored cell.
module wiper_nv_ctrl_chk #(
    parameter int WIPER_W = 7,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int LIMIT   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               stop_evt,
    input logic               busy,
    input logic               recall_pulse,
    input logic               pend,
    input logic [WIPER_W-1:0] wiper,
    input logic [WIPER_W-1:0] stored
);
    logic               rd_w_q, rd_c_q, rd_u_q;
    logic [WIPER_W-1:0] wiper_d;
    int                 run_q;

    // Remember what was requested on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_w_q  <= 1'b0;
            rd_c_q  <= 1'b0;
            rd_u_q  <= 1'b0;
            wiper_d <= '0;
        end else begin
            rd_w_q  <= rd_en && (rd_addr == ADDR_W'(8'h00));
            rd_c_q  <= rd_en && (rd_addr == ADDR_W'(8'h02));
            rd_u_q  <= rd_en && (rd_addr != ADDR_W'(8'h00)) && (rd_addr != ADDR_W'(8'h02));
            wiper_d <= wiper;
        end
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    a_r4_read_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        rd_w_q |-> rd_data == DATA_W'(wiper_d));
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_u_q |-> rd_data == '0);
    a_r5_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c_q |-> rd_data[6:0] == 7'd0);
    a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !recall_pulse) |=> $stable(wiper));
    a_r6_stop_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && pend) |=> busy);
    a_r6_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(stored));
    a_r1_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < LIMIT);
endmodule

bind wiper_nv_ctrl wiper_nv_ctrl_chk #(
    .WIPER_W(WIPER_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LIMIT((WRITE_CYCLES > RECALL_CYCLES) ? WRITE_CYCLES : RECALL_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .stop_evt(stop_evt), .busy(busy),
    .recall_pulse(recall_pulse), .pend(u_regs.pend_q),
    .wiper(wiper), .stored(stored)
);

// File: tb/test_wiper_nv_ctrl.sv
// Bench: directed corner cases followed by seeded random register traffic.
// Expected values come from a small bench-side model of the requirements.
module test_wiper_nv_ctrl;
    localparam int WRC = 20;
    localparam int RCC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, stop_evt = 1'b0, restart_evt = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic [6:0] wiper;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    logic [6:0] m_wr = '0, m_nv = 7'h40, m_pval = '0;
    logic       m_mode = 1'b0, m_pend = 1'b0;

    always #10 clk = ~clk;

    wiper_nv_ctrl #(.WRITE_CYCLES(WRC), .RECALL_CYCLES(RCC)) i_wiper_nv_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_evt(stop_evt), .restart_evt(restart_evt), .busy(busy), .wiper(wiper)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h00)      return {1'b0, m_wr};
        else if (a == 8'h02) return {m_mode, 7'b0};
        else                 return 8'h00;
    endfunction

    task automatic do_reset(input string req);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(req, int'(wiper), 0);
        check(req, int'(busy), 1);
        rst_n = 1'b1;
        begin
            int n = 0;
            while (busy && n < 1000) begin n++; @(negedge clk); end
            check(req, n, RCC);
        end
        m_wr = m_nv; m_mode = 1'b0; m_pend = 1'b0;
        check(req, int'(wiper), int'(m_nv));
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h00) begin
            m_wr = d[6:0];
            if (!m_mode) begin m_pend = 1'b1; m_pval = d[6:0]; end
        end else if (a == 8'h02) begin
            m_mode = d[7];
        end
        check(req, int'(wiper), int'(m_wr));
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, int'(rd_data), int'(exp_read(a)));
    endtask

    task automatic do_stop(input string req);
        bit expect_commit = m_pend;
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
        if (expect_commit) begin
            int n = 0;
            while (busy && n < 1000) begin n++; @(negedge clk); end
            check(req, n, WRC);
            m_nv = m_pval;
        end else begin
            check(req, int'(busy), 0);
        end
        m_pend = 1'b0;
    endtask

    task automatic do_restart();
        restart_evt = 1'b1;
        @(negedge clk);
        restart_evt = 1'b0;
        m_pend = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: first power-up recalls the factory code 40h
        do_reset("R1");
        do_read(8'h00, "R4");
        do_read(8'h02, "R5");
        // R2 and R6: mode-0 write, then STOP commits
        do_write(8'h00, 8'h95, "R2");
        do_stop("R6");
        do_reset("R6");
        // R5: mode bit set, other bits ignored, wiper untouched
        do_write(8'h02, 8'hFF, "R5");
        do_read(8'h02, "R5");
        do_read(8'h00, "R4");
        // R3: mode-1 write stages nothing
        do_write(8'h00, 8'h2A, "R3");
        do_stop("R3");
        do_write(8'h02, 8'h7F, "R5");
        do_read(8'h02, "R5");
        // R10: last write before STOP wins
        do_write(8'h00, 8'h11, "R10");
        do_write(8'h00, 8'h22, "R10");
        stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
        check("R6", int'(busy), 1);
        // R8: write and STOP while busy are ignored
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", int'(wiper), 8'h22);
        stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
        while (busy) @(negedge clk);
        m_nv = 7'h22; m_pend = 1'b0;
        do_stop("R8");
        // R7: repeated START drops the staged value
        do_write(8'h00, 8'h33, "R7");
        do_restart();
        do_stop("R7");
        // R9: unmapped write and read
        do_write(8'h05, 8'h7F, "R9");
        do_read(8'h05, "R9");
        do_read(8'hFF, "R9");
        do_read(8'h02, "R9");
        do_reset("R7");
        // Random register traffic with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 80; i++) begin
            int op = int'($urandom % 6);
            logic [7:0] d = 8'($urandom);
            case (op)
                0: do_write(8'h00, d, "R2");
                1: do_write(8'h02, d, "R5");
                2: do_read(8'($urandom % 4), "R4");
                3: do_write(8'h01 + 8'($urandom % 2) * 8'h02, d, "R9");
                4: do_stop("R6");
                default: do_restart();
            endcase
        end
        do_reset("R6");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule